// File: doc/BRIEF.md
# System Counter with Compare Interrupt

This block is an always-running time base: a 56-bit counter that advances by one on every clock. One compare unit watches it and raises an interrupt when the count has reached a programmed target. Software reaches the block over a simple 32-bit register bus. A write is a single-cycle strobe with an address and data. Read data is combinational from the address, so every read returns the count of the current cycle.

The 56-bit count is read as a low and a high 32-bit word. Software reads high, then low, then high again, and retries if the two high values differ. The target is a 64-bit value written in two halves. The comparison is "target less than or equal to count". A target that is already in the past therefore fires on the next edge once the compare is enabled. A control word holds the enable and the interrupt mask, and it shows a read-only status flag. Software acknowledges an interrupt by clearing the enable. This also clears the status.

Top module: `syscnt_top`

## Requirements
- R1: The counter loads CNT_INIT (default zero) during reset and then increments by one on every rising clock edge. It wraps from 2^56-1 to 0.
- R2: A read at offset 0x08 returns count bits 31:0 and a read at 0x0C returns count bits 55:32 with bits 31:24 zero. Reads are live, so a carry between two reads is visible.
- R3: The target low word (0x10020) and high word (0x10024) are fully read/write 32-bit registers that reset to zero.
- R4: In the control word (0x1002C), bit 0 is enable and bit 1 is mask, both read/write. Bit 2 is the read-only status. Bits 31:3 read zero and ignore writes.
- R5: Status sets on the first rising edge at which enable is already 1 and the target is less than or equal to the zero-extended count sampled at that edge. A past target therefore sets status one edge after the edge that writes enable.
- R6: Once set, status stays set while enable stays 1, even if the target is later raised above the count.
- R7: A write to the control word with bit 0 equal to 0 clears status and enable at that edge, and the interrupt drops.
- R8: irq_o is 1 exactly when status is 1 and mask is 0. The mask does not change status.
- R9: A target with any of bits 63:56 set never fires.
- R10: Reads at unmapped offsets return zero. Writes to the counter offsets or to unmapped offsets change nothing.
- R11: While rst_n is low at a rising edge, the counter, target, enable, mask and status are cleared (the counter to CNT_INIT).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 17 | Byte offset of the register accessed |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Compare interrupt, active high |

## Verification
The assertions assume the following about the inputs:
- Reset is held low for at least one edge before any property matters.
- A write is a one-cycle strobe whose address and data are stable across the rising edge.
- CNT_INIT fits in the counter width.

The bench drives every input at the falling edge and holds reset for several cycles. It samples reads half a cycle later, after the combinational read path settles. It uses two small starting points, one just below the 32-bit carry and one just below the 56-bit wrap. This reaches the carry and wrap boundaries in a few cycles without leaving these assumptions.

// File: rtl/syscnt_pkg.sv
// Shared constants for the system counter: bus geometry, register offsets
// and control-word bit positions. Assumes a 32-bit data bus.
package syscnt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 17;
    localparam int CMP_W  = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 17'h00008;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 17'h0000C;
    localparam logic [ADDR_W-1:0] OFS_CMP_LO = 17'h10020;
    localparam logic [ADDR_W-1:0] OFS_CMP_HI = 17'h10024;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 17'h1002C;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MASK_BIT = 1;
    localparam int CTRL_STAT_BIT = 2;
endpackage

// File: rtl/syscnt_counter.sv
// Free-running up counter. Assumes INIT fits in CNT_W bits.
// Wraps naturally at 2^CNT_W.
module syscnt_counter #(
    parameter int          CNT_W = 56,
    parameter logic [63:0] INIT  = 64'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Load the start value in reset, then advance every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= INIT[CNT_W-1:0];
        else        cnt_q <= cnt_q + ONE;
    end

    assign cnt_o = cnt_q;

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cnt_q == $past(cnt_q) + ONE);
endmodule

// File: rtl/syscnt_cmp.sv
// Magnitude comparator: hit when the target is at or below the
// zero-extended count. Assumes CNT_W <= CMP_W.
module syscnt_cmp #(
    parameter int CNT_W = 56,
    parameter int CMP_W = 64
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CMP_W-1:0] tgt_i,
    output logic             hit_o
);
    logic [CMP_W-1:0] cnt_ext;

    // Widen the count so the target's upper bits take part in the compare.
    always_comb cnt_ext = CMP_W'(cnt_i);

    // Less-or-equal test; no exact match is needed.
    always_comb hit_o = (tgt_i <= cnt_ext);
endmodule

// File: rtl/syscnt_regs.sv
// Target and control registers plus the sticky status flag.
// Assumes single-cycle write strobes and a hit input from the comparator.
module syscnt_regs
    import syscnt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              hit_i,
    output logic [CMP_W-1:0]  tgt_o,
    output logic              en_o,
    output logic              mask_o,
    output logic              stat_o
);
    logic [CMP_W-1:0] tgt_q;
    logic             en_q, mask_q, stat_q;
    logic             ctrl_wr, ack_wr;

    // Decode a control-word write and the acknowledge (enable written 0).
    always_comb begin
        ctrl_wr = wr_i && (addr_i == OFS_CTRL);
        ack_wr  = ctrl_wr && !wdata_i[CTRL_EN_BIT];
    end

    // Target halves, each written as one 32-bit word.
    always_ff @(posedge clk) begin
        if (!rst_n) tgt_q <= '0;
        else if (wr_i && addr_i == OFS_CMP_LO) tgt_q[DATA_W-1:0] <= wdata_i;
        else if (wr_i && addr_i == OFS_CMP_HI) tgt_q[CMP_W-1:DATA_W] <= wdata_i;
    end

    // Enable and mask bits of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mask_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q   <= wdata_i[CTRL_EN_BIT];
            mask_q <= wdata_i[CTRL_MASK_BIT];
        end
    end

    // Status: set on a hit while enabled, held while enabled, cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n)     stat_q <= 1'b0;
        else if (ack_wr) stat_q <= 1'b0;
        else if (!en_q)  stat_q <= 1'b0;
        else if (hit_i)  stat_q <= 1'b1;
    end

    assign tgt_o  = tgt_q;
    assign en_o   = en_q;
    assign mask_o = mask_q;
    assign stat_o = stat_q;

    // R5
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && hit_i && !ack_wr) |=> stat_q);
    // R6
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !ack_wr) |=> stat_q);
    // R7
    stat_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_wr |=> (!stat_q && !en_q));
    // R5
    stat_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q |-> en_q);
endmodule

// File: rtl/syscnt_top.sv
// System counter top: counter, compare registers, comparator and the
// combinational read mux. Assumes CNT_W is between 33 and 64.
module syscnt_top
    import syscnt_pkg::*;
#(
    parameter int          CNT_W    = 56,
    parameter logic [63:0] CNT_INIT = 64'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [CNT_W-1:0] cnt;
    logic [CMP_W-1:0] cnt_ext;
    logic [CMP_W-1:0] tgt;
    logic             hit, en, mask, stat;

    syscnt_counter #(.CNT_W(CNT_W), .INIT(CNT_INIT)) counter_i (
        .clk(clk), .rst_n(rst_n), .cnt_o(cnt)
    );

    syscnt_cmp #(.CNT_W(CNT_W), .CMP_W(CMP_W)) cmp_i (
        .cnt_i(cnt), .tgt_i(tgt), .hit_o(hit)
    );

    syscnt_regs regs_i (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
        .wdata_i(bus_wdata), .hit_i(hit), .tgt_o(tgt), .en_o(en),
        .mask_o(mask), .stat_o(stat)
    );

    // Zero-extended count for splitting into bus words.
    always_comb cnt_ext = CMP_W'(cnt);

    // Live read mux; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CNT_LO: bus_rdata = cnt_ext[DATA_W-1:0];
            OFS_CNT_HI: bus_rdata = cnt_ext[CMP_W-1:DATA_W];
            OFS_CMP_LO: bus_rdata = tgt[DATA_W-1:0];
            OFS_CMP_HI: bus_rdata = tgt[CMP_W-1:DATA_W];
            OFS_CTRL: begin
                bus_rdata[CTRL_EN_BIT]   = en;
                bus_rdata[CTRL_MASK_BIT] = mask;
                bus_rdata[CTRL_STAT_BIT] = stat;
            end
            default: bus_rdata = '0;
        endcase
    end

    // Interrupt request: status gated by the mask.
    always_comb irq_o = stat && !mask;

    // R9
    far_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tgt[CMP_W-1:CNT_W]) |-> !hit);
endmodule

// File: tb/syscnt_top_tb_top.sv
`timescale 1ns/1ps
module syscnt_top_tb_top;
    import syscnt_pkg::*;

    localparam logic [63:0] INIT_A = 64'h0000_00FF_FFFF_FFF0;
    localparam logic [63:0] INIT_W = 64'h00FF_FFFF_FFFF_FFFD;
    localparam logic [63:0] MASK56 = 64'h00FF_FFFF_FFFF_FFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;
    logic [ADDR_W-1:0] w_addr = '0;
    logic [DATA_W-1:0] w_rdata;
    logic              w_irq;
    logic [63:0]       ticks = '0;
    int                checks = 0;
    int                failures = 0;

    always #2.5 clk = ~clk;

    syscnt_top #(.CNT_W(56), .CNT_INIT(INIT_A)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
    );

    syscnt_top #(.CNT_W(56), .CNT_INIT(INIT_W)) dut_w (
        .clk(clk), .rst_n(rst_n), .bus_addr(w_addr), .bus_wr(1'b0),
        .bus_wdata('0), .bus_rdata(w_rdata), .irq_o(w_irq)
    );

    // Count edges seen out of reset; the expected count follows from it.
    always @(posedge clk) begin
        if (!rst_n) ticks <= '0;
        else        ticks <= ticks + 64'd1;
    end

    function automatic logic [63:0] exp_cnt();
        return (INIT_A + ticks) & MASK56;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_now(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin
        #500000;
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        logic [63:0] tgt;
        logic [63:0] e;
        repeat (3) @(negedge clk);
        // R11 / R1: reset state
        rd_now(OFS_CNT_LO, d); check("R11 count lo in reset", {32'd0, d}, {32'd0, INIT_A[31:0]});
        rd_now(OFS_CTRL, d);   check("R11 ctrl in reset", {32'd0, d}, 64'd0);
        rd_now(OFS_CMP_LO, d); check("R3 target lo reset", {32'd0, d}, 64'd0);
        check("R11 irq in reset", {63'd0, irq}, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: wrap of the 56-bit counter
        while (ticks != 64'd2) @(negedge clk);
        w_addr = OFS_CNT_LO; #0.5; check("R1 wrap lo before", {32'd0, w_rdata}, 64'hFFFF_FFFF);
        w_addr = OFS_CNT_HI; #0.5; check("R1 wrap hi before", {32'd0, w_rdata}, 64'h00FF_FFFF);
        @(negedge clk);
        w_addr = OFS_CNT_LO; #0.5; check("R1 wrap lo after", {32'd0, w_rdata}, 64'd0);
        w_addr = OFS_CNT_HI; #0.5; check("R1 wrap hi after", {32'd0, w_rdata}, 64'd0);

        // R2: live split reads across the 32-bit carry
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            e = exp_cnt();
            rd_now(OFS_CNT_LO, d); check("R2 count lo", {32'd0, d}, {32'd0, e[31:0]});
            rd_now(OFS_CNT_HI, d); check("R2 count hi", {32'd0, d}, {32'd0, e[63:32]});
        end

        // R10: counter writes ignored, unmapped reads zero
        bus_write(OFS_CNT_LO, 32'h0);
        rd_now(OFS_CNT_LO, d); e = exp_cnt(); check("R10 counter write ignored", {32'd0, d}, {32'd0, e[31:0]});
        rd_now(17'h00004, d); check("R10 unmapped read", {32'd0, d}, 64'd0);
        rd_now(17'h10028, d); check("R10 unmapped read 2", {32'd0, d}, 64'd0);

        // R3: target readback
        bus_write(OFS_CMP_LO, 32'hA5A5_1234);
        bus_write(OFS_CMP_HI, 32'h5A5A_00FF);
        bus_write(17'h10028, 32'hFFFF_FFFF);
        rd_now(OFS_CMP_LO, d); check("R3 target lo", {32'd0, d}, 64'hA5A5_1234);
        rd_now(OFS_CMP_HI, d); check("R3 target hi", {32'd0, d}, 64'h5A5A_00FF);
        rd_now(OFS_CTRL, d);   check("R10 ctrl after unmapped write", {32'd0, d}, 64'd0);

        // R4: control bits
        bus_write(OFS_CTRL, 32'h0000_0002);
        rd_now(OFS_CTRL, d); check("R4 mask rw", {32'd0, d}, 64'd2);
        bus_write(OFS_CTRL, 32'hFFFF_FFF8);
        rd_now(OFS_CTRL, d); check("R4 upper bits read zero", {32'd0, d}, 64'd0);

        // R9: target with upper bits set never fires
        bus_write(OFS_CMP_LO, 32'h0);
        bus_write(OFS_CMP_HI, 32'h0100_0000);
        bus_write(OFS_CTRL, 32'h1);
        repeat (5) @(negedge clk);
        rd_now(OFS_CTRL, d); check("R9 far target status", {32'd0, d}, 64'd1);
        check("R9 far target irq", {63'd0, irq}, 64'd0);

        // R5: past target fires one edge after enable
        bus_write(OFS_CTRL, 32'h0);
        bus_write(OFS_CMP_HI, 32'h0);
        bus_write(OFS_CTRL, 32'h1);
        check("R5 no status on enable edge", {63'd0, irq}, 64'd0);
        @(negedge clk);
        check("R5 past target fires", {63'd0, irq}, 64'd1);

        // R8: mask hides irq, status kept
        bus_write(OFS_CTRL, 32'h3);
        check("R8 masked irq", {63'd0, irq}, 64'd0);
        rd_now(OFS_CTRL, d); check("R8 status under mask", {32'd0, d}, 64'd7);
        bus_write(OFS_CTRL, 32'h1);
        check("R8 unmasked irq", {63'd0, irq}, 64'd1);

        // R6: status holds after target raised
        bus_write(OFS_CMP_HI, 32'h00FF_FFFF);
        repeat (4) @(negedge clk);
        check("R6 status held", {63'd0, irq}, 64'd1);

        // R7: acknowledge by clearing enable
        bus_write(OFS_CTRL, 32'h0);
        check("R7 irq after ack", {63'd0, irq}, 64'd0);
        rd_now(OFS_CTRL, d); check("R7 ctrl after ack", {32'd0, d}, 64'd0);
        @(negedge clk);
        check("R7 irq stays low", {63'd0, irq}, 64'd0);

        // R5: future target fires exactly when the count passes it
        tgt = exp_cnt() + 64'd20;
        bus_write(OFS_CMP_LO, tgt[31:0]);
        bus_write(OFS_CMP_HI, tgt[63:32]);
        bus_write(OFS_CTRL, 32'h1);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            e = exp_cnt();
            check("R5 future target timing", {63'd0, irq}, {63'd0, ((e - 64'd1) >= tgt)});
        end

        // R11: reset mid-run clears state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R11 irq after reset", {63'd0, irq}, 64'd0);
        rd_now(OFS_CTRL, d);   check("R11 ctrl after reset", {32'd0, d}, 64'd0);
        rd_now(OFS_CMP_LO, d); check("R11 target after reset", {32'd0, d}, 64'd0);
        rd_now(OFS_CNT_LO, d); check("R11 count after reset", {32'd0, d}, {32'd0, INIT_A[31:0]});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule